// File: doc/BRIEF.md
# Counter-Ramp Conversion Sequencer

This block runs a single-slope analog-to-digital conversion using three parts outside the chip. An N-bit binary counter drives an external DAC. An external comparator reports whether the held analog level is still above the DAC output. A sample/hold control line tells the external S/H stage either to track the input or to freeze it.

A start request in the idle state does three things:

- It zeroes the counter.
- It opens a sample window whose length is programmable.
- It then switches the S/H stage to hold.

After that the counter climbs one code at a time. It advances only on clocks where the count-enable input is high. Each decision waits until the synchronized comparator has seen the current DAC code.

When the comparator stops reporting "above", the code is latched as the result and a one-clock done strobe is raised. If the counter reaches full scale while the input is still above, the conversion ends with full scale and a saturation flag. A conversion therefore takes a number of steps that depends on the input value, up to 2^N evaluations.

Top module: `ramp_adc_ctrl`

## Requirements
- R1: A start request in idle clears the DAC code to 0 on the next clock edge. In the following cycle `busy_o` and `sample_o` are both 1.
- R2: The sample window lasts exactly `acq_cycles_i`+1 clocks. The value of `acq_cycles_i` is taken at the start request.
- R3: After the sample window, `sample_o` stays 0 until the conversion ends. Input changes during that time do not affect the result.
- R4: The DAC code moves only upward, by exactly 1, and only on a clock where `tick_i` is 1 and the synchronized comparator reads "above". Every code, including 0, is held for two settle clocks and then evaluated on the next `tick_i` clock. With `tick_i` held at 1, a conversion keeps `busy_o` high for `acq_cycles_i`+1+3*(result+1) clocks.
- R5: The result is the first code at which the comparator no longer reports "above". `done_o` is 1 for exactly one clock. `result_o` is valid in that clock and keeps its value until the next conversion ends.
- R6: If the comparator still reads "above" when the code is all-ones (2^WIDTH-1), `result_o` is all-ones and `sat_o` is 1. Otherwise `sat_o` is 0.
- R7: A start request while `busy_o` is 1 is ignored. The conversion in progress gives its normal result, and `busy_o` is 0 after `done_o`.
- R8: `cmp_above_i` passes through a two-stage synchronizer before any decision uses it.
- R9: After reset, the DAC code, `result_o`, `sat_o`, `done_o`, `busy_o` and `sample_o` are all 0. `sample_o` is never 1 while `busy_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Conversion request, taken only in idle |
| acq_cycles_i | input | ACQ_W | Sample window length minus one |
| tick_i | input | 1 | Count enable for decision cycles |
| cmp_above_i | input | 1 | Comparator: held input above DAC output (asynchronous) |
| dac_code_o | output | WIDTH | Code driven to the external DAC |
| sample_o | output | 1 | 1 = S/H tracks, 0 = S/H holds |
| busy_o | output | 1 | Conversion in progress |
| done_o | output | 1 | One-clock end-of-conversion strobe |
| result_o | output | WIDTH | Latched conversion result |
| sat_o | output | 1 | Result clipped at full scale |

## Verification
The assertions assume that `cmp_above_i` behaves like a real comparator: it reflects the held level against the current DAC code and settles within the two synchronizer stages. They also assume that a start pulse only ever lands in idle or busy cycles, and never in a reset.

The bench models the S/H stage as a register that is loaded only while `sample_o` is 1. The comparator is modelled as a direct compare against `dac_code_o`. The analog level is redrawn at random as soon as hold begins, so a wrong hold window shows up as a wrong result. `tick_i` is either held at 1 or drawn at random, which keeps the count enable inside the legal pattern of any clock.

// File: rtl/ramp_adc_pkg.sv
package ramp_adc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SAMPLE = 2'd1,
    ST_COUNT  = 2'd2
  } ramp_state_e;

  localparam int unsigned SYNC_STAGES = 2;
  localparam int unsigned SETTLE_CLKS = SYNC_STAGES;
endpackage

// File: rtl/ramp_sync.sv
module ramp_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], d_i};
  end

  assign q_o = sync_q[STAGES-1];
endmodule

// File: rtl/ramp_counter.sv
module ramp_counter #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             inc_i,
  output logic [WIDTH-1:0] cnt_o,
  output logic             full_o
);
  logic [WIDTH-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (clr_i) cnt_q <= '0;
    else if (inc_i) cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o  = cnt_q;
  assign full_o = &cnt_q;
endmodule

// File: rtl/ramp_seq.sv
module ramp_seq
  import ramp_adc_pkg::*;
#(
  parameter int unsigned ACQ_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [ACQ_W-1:0] acq_cycles_i,
  input  logic             tick_i,
  input  logic             above_i,
  input  logic             full_i,
  output logic             clr_o,
  output logic             inc_o,
  output logic             finish_o,
  output logic             sat_o,
  output logic             sample_o,
  output logic             busy_o
);
  localparam int unsigned SETTLE_W = $clog2(SETTLE_CLKS + 1);
  localparam logic [SETTLE_W-1:0] SETTLE_LOAD = SETTLE_W'(SETTLE_CLKS);

  ramp_state_e      state_q;
  logic [ACQ_W-1:0] acq_q;
  logic [SETTLE_W-1:0] settle_q;
  logic             decide;

  // evaluate only once the synchronizer reflects the current code
  assign decide   = (state_q == ST_COUNT) && (settle_q == '0) && tick_i;
  assign inc_o    = decide && above_i && !full_i;
  assign finish_o = decide && (!above_i || full_i);
  assign sat_o    = above_i && full_i;
  assign clr_o    = (state_q == ST_IDLE) && start_i;
  assign sample_o = (state_q == ST_SAMPLE);
  assign busy_o   = (state_q != ST_IDLE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      acq_q    <= '0;
      settle_q <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            state_q <= ST_SAMPLE;
            acq_q   <= acq_cycles_i;
          end
        end
        ST_SAMPLE: begin
          if (acq_q == '0) begin
            state_q  <= ST_COUNT;
            settle_q <= SETTLE_LOAD;
          end else begin
            acq_q <= acq_q - 1'b1;
          end
        end
        ST_COUNT: begin
          if (finish_o)            state_q  <= ST_IDLE;
          else if (inc_o)          settle_q <= SETTLE_LOAD;
          else if (settle_q != '0) settle_q <= settle_q - 1'b1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ramp_adc_ctrl.sv
module ramp_adc_ctrl
  import ramp_adc_pkg::*;
#(
  parameter int unsigned WIDTH = 8,
  parameter int unsigned ACQ_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [ACQ_W-1:0] acq_cycles_i,
  input  logic             tick_i,
  input  logic             cmp_above_i,
  output logic [WIDTH-1:0] dac_code_o,
  output logic             sample_o,
  output logic             busy_o,
  output logic             done_o,
  output logic [WIDTH-1:0] result_o,
  output logic             sat_o
);
  logic             above_s;
  logic             clr, inc, full, finish, sat_now;
  logic [WIDTH-1:0] cnt;
  logic [WIDTH-1:0] result_q;
  logic             sat_q, done_q;

  ramp_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (cmp_above_i),
    .q_o   (above_s)
  );

  ramp_counter #(.WIDTH(WIDTH)) u_cnt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (clr),
    .inc_i (inc),
    .cnt_o (cnt),
    .full_o(full)
  );

  ramp_seq #(.ACQ_W(ACQ_W)) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .acq_cycles_i(acq_cycles_i),
    .tick_i      (tick_i),
    .above_i     (above_s),
    .full_i      (full),
    .clr_o       (clr),
    .inc_o       (inc),
    .finish_o    (finish),
    .sat_o       (sat_now),
    .sample_o    (sample_o),
    .busy_o      (busy_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      result_q <= '0;
      sat_q    <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      done_q <= finish;
      if (finish) begin
        result_q <= cnt;
        sat_q    <= sat_now;
      end
    end
  end

  assign dac_code_o = cnt;
  assign result_o   = result_q;
  assign sat_o      = sat_q;
  assign done_o     = done_q;
endmodule

// File: rtl/ramp_adc_ctrl_chk.sv
module ramp_adc_ctrl_chk #(
  parameter int unsigned WIDTH = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             tick_i,
  input logic             sample_o,
  input logic             busy_o,
  input logic             done_o,
  input logic [WIDTH-1:0] dac_code_o,
  input logic [WIDTH-1:0] result_o,
  input logic             sat_o
);
  a_r1_clear_on_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> (dac_code_o == '0 && sample_o));

  a_r3_no_resample: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !sample_o) |=> (!sample_o || !busy_o));

  a_r4_single_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o) && dac_code_o != $past(dac_code_o))
      |-> (dac_code_o == $past(dac_code_o) + 1'b1));

  a_r4_step_needs_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(busy_o) && !$past(sample_o) && dac_code_o != $past(dac_code_o))
      |-> $past(tick_i));

  a_r5_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r6_sat_full_scale: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sat_o |-> (result_o == {WIDTH{1'b1}}));

  a_r9_idle_no_sample: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !sample_o);
endmodule

bind ramp_adc_ctrl ramp_adc_ctrl_chk #(.WIDTH(WIDTH)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .tick_i    (tick_i),
  .sample_o  (sample_o),
  .busy_o    (busy_o),
  .done_o    (done_o),
  .dac_code_o(dac_code_o),
  .result_o  (result_o),
  .sat_o     (sat_o)
);

// File: tb/ramp_adc_ctrl_bench.sv
`timescale 1ns/1ps
module ramp_adc_ctrl_bench;
  localparam int W     = 8;
  localparam int AW    = 4;
  localparam int MAXC  = (1 << W) - 1;
  localparam int LIMIT = 190000;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          start_i = 1'b0;
  logic [AW-1:0] acq_cycles_i = '0;
  logic          tick_i = 1'b1;
  logic          cmp_above_i;
  logic [W-1:0]  dac_code_o, result_o;
  logic          sample_o, busy_o, done_o, sat_o;

  int  vin = 0, held = 0;
  bit  rnd_tick = 1'b0;
  int  n_checks = 0, n_fail = 0, cycles = 0;

  always #2.5 clk_i = ~clk_i;

  ramp_adc_ctrl #(.WIDTH(W), .ACQ_W(AW)) u_ramp_adc_ctrl (
    .clk_i, .rst_ni, .start_i, .acq_cycles_i, .tick_i, .cmp_above_i,
    .dac_code_o, .sample_o, .busy_o, .done_o, .result_o, .sat_o
  );

  // external S/H and comparator model
  always @(posedge clk_i) if (sample_o) held <= vin;
  assign cmp_above_i = (held > int'(dac_code_o));

  always @(negedge clk_i) begin
    tick_i <= rnd_tick ? 1'($urandom % 2) : 1'b1;
    if (busy_o && !sample_o) vin <= int'($urandom % 300);
  end

  always @(posedge clk_i) begin
    cycles++;
    if (cycles > LIMIT) begin
      n_fail++;
      $display("FAIL watchdog: act %0d cycles exp <= %0d", cycles, LIMIT);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  function automatic int exp_result(int v);
    return (v > MAXC) ? MAXC : v;
  endfunction

  function automatic int exp_busy(int acq, int r);
    return acq + 1 + 3 * (r + 1);
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: act %0d exp %0d", req, act, exp);
    end
  endtask

  task automatic run_conv(int v, int acq, bit rt, bit poke);
    int n_sample = 0, n_busy = 0, guard = 0;
    int er, res0;
    @(negedge clk_i);
    vin = v; acq_cycles_i = AW'(acq); rnd_tick = rt; start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    check(dac_code_o == '0 && sample_o && busy_o, "R1 clear+sample", int'(dac_code_o), 0);
    while (!done_o && guard < 20000) begin
      if (sample_o) n_sample++;
      if (busy_o) n_busy++;
      start_i = (poke && n_busy == acq + 5);
      guard++;
      @(negedge clk_i);
    end
    start_i = 1'b0;
    check(guard < 20000, "R5 done reached", guard, 20000);
    er = exp_result(v);
    check(int'(result_o) == er, "R5/R3 result", int'(result_o), er);
    check(sat_o == (v > MAXC), "R6 sat flag", int'(sat_o), int'(v > MAXC));
    check(n_sample == acq + 1, "R2 sample window", n_sample, acq + 1);
    if (!rt)
      check(n_busy == exp_busy(acq, er), "R4/R8 conversion length", n_busy, exp_busy(acq, er));
    res0 = int'(result_o);
    @(negedge clk_i);
    check(!done_o, "R5 done one clock", int'(done_o), 0);
    check(int'(result_o) == res0, "R5 result held", int'(result_o), res0);
    if (poke) check(!busy_o, "R7 start while busy ignored", int'(busy_o), 0);
  endtask

  initial begin
    void'($urandom(32'd1234));
    #1;
    check(dac_code_o == '0 && result_o == '0 && !sat_o && !done_o && !busy_o && !sample_o,
          "R9 reset state", int'(dac_code_o), 0);
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check(!busy_o && !sample_o && dac_code_o == '0, "R9 after reset", int'(busy_o), 0);

    run_conv(0,    0,  1'b0, 1'b0);
    run_conv(1,    15, 1'b0, 1'b0);
    run_conv(MAXC - 1, 3, 1'b0, 1'b1);
    run_conv(MAXC, 0,  1'b0, 1'b0);   // R6 exactly full scale, no sat
    run_conv(MAXC + 1, 2, 1'b0, 1'b0); // R6 saturation
    run_conv(300,  7,  1'b1, 1'b1);
    run_conv(37,   5,  1'b1, 1'b1);   // R7 poke mid-count

    for (int i = 0; i < 30; i++) begin
      run_conv(int'($urandom % 280), int'($urandom % 16), 1'($urandom % 2), 1'($urandom % 2));
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule